// File: doc/BRIEF.md
# Pin-Change Wake Comparator

This block watches a group of general-purpose input pins while the system sits in a low-power stop state and raises a wake request when a watched pin leaves its expected level. Each pin passes through a two-stage synchroniser. The synchronised levels are compared against an expected pattern, and the OR of all per-pin mismatches is registered once before it leaves the block as `wake`.

The expected pattern depends on a two-bit mode field. In the level mode, code 00, a watched pin must stay high, so a low level on it wakes the system. Once at least one pin is armed, every read of the port data register captures the sampled pin levels as the reference and sets the mode to 01. Every write of the port data register captures the written byte as the reference and sets the mode to 10. In both reference modes, any armed pin that differs from its reference bit wakes the system. Software can write 00 into the mode field to return to level detection.

Registers sit at four word addresses:
- address 0: port data
- address 1: direction, where a 1 bit makes the pin an input
- address 2: watch mask
- address 3: mode field in bits [1:0]

A pin is armed only when both its mask bit and its direction bit are 1.

Top module: `pinwake_cmp`

## Requirements
- R1: Reset clears the watch mask to 0, the mode field to 00 and the reference to all zeros. Reset sets every direction bit to 1 (input), so `pin_oe` reads 0. `wake` is 0 after reset.
- R2: Pin i is armed only when mask bit i and direction bit i are both 1. A pin that is not armed never causes `wake`, whatever its level.
- R3: In mode 00, `wake` becomes 1 when any armed pin's synchronised level is 0. It is 0 when every armed pin is at level 1.
- R4: A read at address 0 while at least one pin is armed stores the synchronised pin levels as the reference and sets the mode field to 01.
- R5: A write at address 0 always updates the output data latch `pin_out`. When at least one pin is armed, the same write also stores the written byte as the reference and sets the mode field to 10. If `reg_wr` and `reg_rd` are both high in one cycle, only the write takes effect.
- R6: In mode 01 or 10, `wake` becomes 1 when any armed pin's synchronised level differs from its reference bit. It is 0 when all armed pins match.
- R7: Writing address 3 with data bits [1:0] equal to 00 sets the mode field to 00. A write at address 3 with any other value in bits [1:0] leaves the mode field unchanged.
- R8: While no pin is armed, reads and writes at address 0 leave the mode field and the reference unchanged.
- R9: A pin change at the inputs appears on `wake` at the third rising clock edge after it: two synchroniser stages, then the output register.
- R10: The mode field never holds 11. Whichever of a data read or a data write came last sets the mode.
- R11: `reg_rdata` is combinational and depends on `reg_addr`:
  - address 0 returns the synchronised pin levels;
  - address 1 returns the direction bits;
  - address 2 returns the watch mask;
  - address 3 returns the mode field in bits [1:0], with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | N_PINS | Asynchronous pin levels |
| pin_out | output | N_PINS | Output data latch |
| pin_oe | output | N_PINS | Output enable per pin, 1 where the direction bit is 0 |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 may latch a reference |
| reg_wdata | input | N_PINS | Register write data |
| reg_rdata | output | N_PINS | Register read data |
| wake | output | 1 | Registered wake request |

## Verification
The bench builds the block with the default parameters: eight pins and two synchroniser stages. With eight pins, the byte patterns it drives can arm a single pin, a pin configured as an output, or all eight pins at once. With two stages, the three-edge latency of R9 can be checked edge by edge. Because reference capture depends on the access type, the bench alternates data reads and data writes. It checks which one set the mode and which value became the reference, and it observes the reference through `wake` after re-arming.

// File: rtl/pinwake_pkg.sv
package pinwake_pkg;

    localparam int unsigned REG_ADDR_W = 2;
    localparam int unsigned MODE_W     = 2;

    typedef enum logic [MODE_W-1:0] {
        WM_LEVEL    = 2'b00,
        WM_READREF  = 2'b01,
        WM_WRITEREF = 2'b10
    } wake_mode_e;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_DATA = 2'd0,
        RA_DIR  = 2'd1,
        RA_MASK = 2'd2,
        RA_MODE = 2'd3
    } reg_addr_e;

    // Decoded bus access for one cycle
    typedef struct packed {
        logic      wr;
        logic      rd;
        reg_addr_e addr;
    } bus_acc_t;

    function automatic logic is_ref_mode(wake_mode_e m);
        return m != WM_LEVEL;
    endfunction

    // Only code 00 written to the mode field has an effect
    function automatic logic is_mode_clear(logic [MODE_W-1:0] v);
        return v == 2'b00;
    endfunction

endpackage

// File: rtl/pinwake_sync.sv
module pinwake_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pinwake_regs.sv
module pinwake_regs
    import pinwake_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_acc_t     acc,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pins_sync,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] mask_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] ref_q,
    output wake_mode_e   mode_q,
    output logic [W-1:0] armed,
    output logic [W-1:0] rdata
);
    logic any_armed;
    logic data_rd;

    assign armed     = mask_q & dir_q;
    assign any_armed = |armed;
    assign data_rd   = acc.rd && !acc.wr && (acc.addr == RA_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q  <= '1;
            mask_q <= '0;
            out_q  <= '0;
            ref_q  <= '0;
            mode_q <= WM_LEVEL;
        end else if (acc.wr) begin
            case (acc.addr)
                RA_DATA: begin
                    out_q <= wdata;
                    if (any_armed) begin
                        ref_q  <= wdata;
                        mode_q <= WM_WRITEREF;
                    end
                end
                RA_DIR:  dir_q  <= wdata;
                RA_MASK: mask_q <= wdata;
                RA_MODE: if (is_mode_clear(wdata[MODE_W-1:0])) mode_q <= WM_LEVEL;
                default: ;
            endcase
        end else if (data_rd && any_armed) begin
            ref_q  <= pins_sync;
            mode_q <= WM_READREF;
        end
    end

    always_comb begin
        case (acc.addr)
            RA_DATA: rdata = pins_sync;
            RA_DIR:  rdata = dir_q;
            RA_MASK: rdata = mask_q;
            RA_MODE: rdata = {{(W-MODE_W){1'b0}}, mode_q};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pinwake_detect.sv
module pinwake_detect
    import pinwake_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins_sync,
    input  logic [W-1:0] ref_q,
    input  logic [W-1:0] armed,
    input  wake_mode_e   mode_q,
    output logic         wake_q
);
    logic [W-1:0] expect_v;
    logic [W-1:0] miss;
    logic         use_ref;

    assign use_ref = is_ref_mode(mode_q);

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Level mode expects a high pin; reference modes expect the stored bit
        assign expect_v[i] = use_ref ? ref_q[i] : 1'b1;
        assign miss[i]     = armed[i] & (pins_sync[i] ^ expect_v[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) wake_q <= 1'b0;
        else     wake_q <= |miss;
    end
endmodule

// File: rtl/pinwake_cmp.sv
module pinwake_cmp
    import pinwake_pkg::*;
#(
    parameter int unsigned N_PINS      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_PINS-1:0]     pin_in,
    output logic [N_PINS-1:0]     pin_out,
    output logic [N_PINS-1:0]     pin_oe,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [N_PINS-1:0]     reg_wdata,
    output logic [N_PINS-1:0]     reg_rdata,
    output logic                  wake
);
    bus_acc_t          acc;
    logic [N_PINS-1:0] pins_sync;
    logic [N_PINS-1:0] dir_q;
    logic [N_PINS-1:0] mask_q;
    logic [N_PINS-1:0] out_q;
    logic [N_PINS-1:0] ref_q;
    logic [N_PINS-1:0] armed;
    wake_mode_e        mode_q;

    assign acc.wr   = reg_wr;
    assign acc.rd   = reg_rd;
    assign acc.addr = reg_addr_e'(reg_addr);

    pinwake_sync #(.W(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_in),
        .dout (pins_sync)
    );

    pinwake_regs #(.W(N_PINS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .acc       (acc),
        .wdata     (reg_wdata),
        .pins_sync (pins_sync),
        .dir_q     (dir_q),
        .mask_q    (mask_q),
        .out_q     (out_q),
        .ref_q     (ref_q),
        .mode_q    (mode_q),
        .armed     (armed),
        .rdata     (reg_rdata)
    );

    pinwake_detect #(.W(N_PINS)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .pins_sync (pins_sync),
        .ref_q     (ref_q),
        .armed     (armed),
        .mode_q    (mode_q),
        .wake_q    (wake)
    );

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
endmodule

// File: rtl/pinwake_chk.sv
module pinwake_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [1:0]   reg_addr,
    input logic         reg_wr,
    input logic         reg_rd,
    input logic [W-1:0] reg_wdata,
    input logic [W-1:0] pins_sync,
    input logic [W-1:0] ref_q,
    input logic [W-1:0] armed,
    input logic [1:0]   mode_q,
    input logic         wake
);
    assert_mode_legal_R10: assert property (@(posedge clk) disable iff (rst)
        mode_q != 2'b11);

    assert_unarmed_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (armed == '0) |=> !wake);

    assert_level_wake_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b00 && (armed & ~pins_sync) != '0) |=> wake);

    assert_read_ref_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && !reg_wr && reg_addr == 2'd0 && armed != '0)
        |=> (mode_q == 2'b01 && ref_q == $past(pins_sync)));

    assert_write_ref_R5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && armed != '0)
        |=> (mode_q == 2'b10 && ref_q == $past(reg_wdata)));

    assert_mode_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd3 && reg_wdata[1:0] == 2'b00) |=> mode_q == 2'b00);

    assert_unarmed_hold_R8: assert property (@(posedge clk) disable iff (rst)
        ((reg_wr || reg_rd) && reg_addr == 2'd0 && armed == '0)
        |=> ($stable(mode_q) && $stable(ref_q)));
endmodule

bind pinwake_cmp pinwake_chk #(.W(N_PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_wdata (reg_wdata),
    .pins_sync (pins_sync),
    .ref_q     (ref_q),
    .armed     (armed),
    .mode_q    (mode_q),
    .wake      (wake)
);

// File: tb/pinwake_cmp_bench.sv
`timescale 1ns/1ps
module pinwake_cmp_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pin_out, pin_oe;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       wake;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    pinwake_cmp u_pinwake_cmp (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wake(wake)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk); pin_in = v;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_rd(2'd1, d); check("R1 dir after reset", d, 8'hFF);
        bus_rd(2'd2, d); check("R1 mask after reset", d, 8'h00);
        bus_rd(2'd3, d); check("R1 mode after reset", d, 8'h00);
        check("R1 wake after reset", {7'd0, wake}, 8'h00);
        check("R1 pin_oe after reset", pin_oe, 8'h00);
    endtask

    task automatic t_default();
        set_pins(8'hFF); bus_wr(2'd2, 8'h01); settle();
        check("R3 high pin no wake", {7'd0, wake}, 8'h00);
        set_pins(8'hFE); settle();
        check("R3 low armed pin wakes", {7'd0, wake}, 8'h01);
        bus_wr(2'd2, 8'h00); set_pins(8'h00); settle();
        check("R2 mask off no wake", {7'd0, wake}, 8'h00);
        bus_wr(2'd2, 8'h02); bus_wr(2'd1, 8'hFD); settle();
        check("R2 output pin no wake", {7'd0, wake}, 8'h00);
        check("R2 pin_oe follows dir", pin_oe, 8'h02);
        bus_wr(2'd1, 8'hFF); settle();
        check("R2 input again wakes", {7'd0, wake}, 8'h01);
    endtask

    task automatic t_read_ref();
        logic [7:0] d;
        set_pins(8'h5A); bus_wr(2'd2, 8'hFF); settle();
        bus_rd(2'd0, d); check("R11 data read gives pins", d, 8'h5A);
        bus_rd(2'd3, d); check("R4 mode after read", d, 8'h01);
        settle(); check("R6 match no wake", {7'd0, wake}, 8'h00);
        set_pins(8'h5B); settle();
        check("R6 differ wakes (read ref)", {7'd0, wake}, 8'h01);
        set_pins(8'h5A); settle();
        check("R6 back to match", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_write_ref();
        logic [7:0] d;
        bus_wr(2'd0, 8'h3C);
        bus_rd(2'd3, d); check("R5 mode after write", d, 8'h02);
        check("R5 pin_out latch", pin_out, 8'h3C);
        set_pins(8'h3C); settle();
        check("R6 written ref match", {7'd0, wake}, 8'h00);
        set_pins(8'h3D); settle();
        check("R6 written ref differ", {7'd0, wake}, 8'h01);
        set_pins(8'h3C); settle();
    endtask

    task automatic t_order();
        logic [7:0] d;
        bus_rd(2'd0, d); bus_rd(2'd3, d); check("R10 read after write", d, 8'h01);
        bus_wr(2'd0, 8'h3C); bus_rd(2'd3, d); check("R10 write after read", d, 8'h02);
        bus_rd(2'd0, d); bus_rd(2'd3, d); check("R10 read wins again", d, 8'h01);
    endtask

    task automatic t_clear();
        logic [7:0] d;
        bus_wr(2'd3, 8'h03); bus_rd(2'd3, d); check("R7 nonzero write ignored", d, 8'h01);
        settle(); check("R7 still in ref mode", {7'd0, wake}, 8'h00);
        bus_wr(2'd3, 8'h00); bus_rd(2'd3, d); check("R7 clear to level", d, 8'h00);
        settle(); check("R7 level mode wakes on zeros", {7'd0, wake}, 8'h01);
    endtask

    task automatic t_unarmed();
        logic [7:0] d;
        bus_wr(2'd0, 8'hAA); set_pins(8'hAA); settle();
        check("R6 ref AA match", {7'd0, wake}, 8'h00);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd0, 8'h55); bus_rd(2'd0, d);
        check("R8 latch still updated", pin_out, 8'h55);
        bus_wr(2'd2, 8'hFF);
        bus_rd(2'd3, d); check("R8 mode unchanged", d, 8'h02);
        settle(); check("R8 reference unchanged", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk); pin_in = 8'hAB;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R9 no wake after two edges", {7'd0, wake}, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R9 wake at third edge", {7'd0, wake}, 8'h01);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        t_reset();
        t_default();
        t_read_ref();
        t_write_ref();
        t_order();
        t_clear();
        t_unarmed();
        t_latency();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule